// File: doc/BRIEF.md
# Dual-Lane Sampled-Data Serial Source

This block stands in for the digital side of a two-channel data converter, so that a host-side serial reader can be exercised against a synthesizable partner. A rising edge on the conversion-start pin captures two sample words from the parallel inputs. It also raises a busy flag for a fixed number of system clocks. A host then lowers chip select and pulls the two words out bit by bit with a serial clock.

All pins are sampled in the system clock domain, and every edge is found by comparison with the previous sample. In two-lane mode the two words go out side by side, one per data line. In one-lane mode the first line carries both words back to back. There, a frame split after the first word with a chip-select pulse picks up again at the second word. Each data line has its own output-enable that stands for the high-impedance state. When chip select falls, the pair to send is copied into a frame register. A conversion that lands during a read therefore cannot change a frame that has already begun.

Top module: `adcemu_top`

## Requirements
- R1: While reset is held and on the first clock after it, busy is low, both output-enables are low and both data lines are 0.
- R2: A rising edge of `conv_start` seen while busy is low raises `busy` on the next clock. Busy then stays high for exactly CONV_CYCLES clocks and drops.
- R3: A rising edge of `conv_start` that arrives while busy is high is ignored. The busy period is not extended and the stored words are not replaced.
- R4: The words sent are the values on `smp_a` and `smp_b` in the clock where the start edge was taken, even if those inputs change later.
- R5: While `cs_n` is high, both enables and both data lines are 0. From the clock after `cs_n` falls, `sdo_a_oe` is 1, and `sdo_b_oe` is 1 only in two-lane mode.
- R6: On the clock after a `cs_n` fall, with no serial clock edge needed, each active line shows bit 15 (the MSB) of its word.
- R7: Each rising edge of `sclk` while `cs_n` is low moves each active line on by one bit, MSB first. In two-lane mode `sdo_a` carries word A and `sdo_b` carries word B.
- R8: Once every bit of the frame has been sent, each enabled data line shows 0 until `cs_n` rises, whatever further `sclk` edges arrive.
- R9: When `one_wire` is 1 at the `cs_n` fall, `sdo_b_oe` and `sdo_b` stay 0. `sdo_a` sends the 16 bits of A and then the 16 bits of B, 32 bits in all.
- R10: In one-lane mode, if `cs_n` rises after exactly 16 `sclk` rises, the next fall goes on with B's MSB. Any other count, and every case in two-lane mode, makes the next fall start again at A's MSB.
- R11: The frame is fixed at the `cs_n` fall that starts it, and a resumed frame keeps that copy. A start edge in the same clock as that fall, or a conversion in the middle of a frame, changes no bit of the frame. A `sclk` rise in the same clock as a `cs_n` fall does not advance the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_start | input | 1 | Conversion start; its rising edge begins a conversion |
| cs_n | input | 1 | Chip select, active low; frames a read |
| sclk | input | 1 | Serial clock; each rising edge advances one bit |
| one_wire | input | 1 | 1 selects one-lane mode; copied at the frame start |
| smp_a | input | 16 | Channel A sample word, captured at a start edge |
| smp_b | input | 16 | Channel B sample word, captured at a start edge |
| busy | output | 1 | High while a conversion is in progress |
| sdo_a | output | 1 | First serial data line |
| sdo_a_oe | output | 1 | Drive enable for sdo_a (0 means high impedance) |
| sdo_b | output | 1 | Second serial data line |
| sdo_b_oe | output | 1 | Drive enable for sdo_b (0 means high impedance) |

## Verification
A conversion start can land in the same clock as the chip-select fall that copies the frame. The bench drives both pins on the same half-cycle with new sample words. It passes if the whole frame still carries the previous pair and the next read carries the new one. A serial clock rise can also coincide with that chip-select fall. For that case the bench checks that the MSB is presented and held for a further clock. A conversion is also run between the two halves of a split one-lane frame, and the resumed half must still send the older B word.

// File: rtl/adcemu_pkg.sv
// adcemu_pkg: types shared by the serial source blocks.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package adcemu_pkg;

    // Lane layout latched at the start of a read frame.
    typedef enum logic {
        LANE_DUAL   = 1'b0,
        LANE_SINGLE = 1'b1
    } lane_mode_e;

endpackage : adcemu_pkg

// File: rtl/adcemu_edge.sv
// adcemu_edge: finds rising and falling edges on N level inputs that are
// sampled by clk. Assumes the inputs are already synchronous to clk and
// hold each level for at least one clock. RST_LVL gives the level assumed
// before reset ends, so an idle pin shows no edge when reset is released.
module adcemu_edge #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    // Hold the previous sample of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_LVL;
        end else begin
            prev_q <= lvl;
        end
    end

    // Per-bit edge decode.
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise[g] = lvl[g] & ~prev_q[g];
        assign fall[g] = ~lvl[g] & prev_q[g];
    end

endmodule : adcemu_edge

// File: rtl/adcemu_conv.sv
// adcemu_conv: conversion timer and result store. A start edge taken while
// idle copies both sample words and holds busy high for CONV_CYCLES clocks.
// Start edges taken while busy are dropped. Assumes CONV_CYCLES >= 1.
module adcemu_conv #(
    parameter int WORD_W      = 16,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rise,
    input  logic [WORD_W-1:0] smp_a,
    input  logic [WORD_W-1:0] smp_b,
    output logic              busy,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_b
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] left_q;

    // Start, count down and finish a conversion; capture words at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            res_a  <= '0;
            res_b  <= '0;
        end else if (start_rise && !busy_q) begin
            busy_q <= 1'b1;
            left_q <= CNT_LOAD;
            res_a  <= smp_a;
            res_b  <= smp_b;
        end else if (busy_q) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    assign busy = busy_q;

endmodule : adcemu_conv

// File: rtl/adcemu_shift.sv
// adcemu_shift: read-frame serialiser. A chip-select fall copies the stored
// pair and the lane mode into a frame register, unless a one-lane frame was
// paused at the word boundary, in which case the old copy and position are
// kept. Serial clock rises step a bit pointer; the lines are registered from
// next-state values, so each change shows one clock after the pin edge.
// Assumes the chip-select and serial clock edges come from adcemu_edge.
module adcemu_shift
    import adcemu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  lane_mode_e        mode_in,
    input  logic [WORD_W-1:0] res_a,
    input  logic [WORD_W-1:0] res_b,
    output logic              sdo_a,
    output logic              sdo_a_oe,
    output logic              sdo_b,
    output logic              sdo_b_oe
);

    localparam int FRAME_W = 2 * WORD_W;
    localparam int PTR_W   = $clog2(FRAME_W + 1);
    localparam logic [PTR_W-1:0] HALF = PTR_W'(WORD_W);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(FRAME_W);

    logic [FRAME_W-1:0] frame_q, frame_d;
    lane_mode_e         mode_q, mode_d;
    logic [PTR_W-1:0]   ptr_q, ptr_d;
    logic               resume_q, resume_d;
    logic [PTR_W-1:0]   lim_q, lim_d;
    logic [FRAME_W-1:0] view;
    logic               more;
    logic               a_d, b_d, oe_a_d, oe_b_d;

    assign lim_q = (mode_q == LANE_SINGLE) ? FULL : HALF;
    assign lim_d = (mode_d == LANE_SINGLE) ? FULL : HALF;

    // Frame, mode, pointer and resume flag; a chip-select fall wins over sclk.
    always_comb begin
        frame_d  = frame_q;
        mode_d   = mode_q;
        ptr_d    = ptr_q;
        resume_d = resume_q;
        if (cs_fall) begin
            if (!resume_q) begin
                frame_d = {res_a, res_b};
                mode_d  = mode_in;
                ptr_d   = '0;
            end
            resume_d = 1'b0;
        end else if (cs_rise) begin
            resume_d = (mode_q == LANE_SINGLE) && (ptr_q == HALF);
        end else if (cs_low && sclk_rise && (ptr_q < lim_q)) begin
            ptr_d = ptr_q + PTR_W'(1);
        end
    end

    // Line values for the next clock: bit under the pointer, zero past the end.
    always_comb begin
        view   = frame_d << ptr_d;
        more   = ptr_d < lim_d;
        oe_a_d = cs_low;
        oe_b_d = cs_low && (mode_d == LANE_DUAL);
        a_d    = oe_a_d && more && view[FRAME_W-1];
        b_d    = oe_b_d && more && view[WORD_W-1];
    end

    // Register frame state and all four line outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q  <= '0;
            mode_q   <= LANE_DUAL;
            ptr_q    <= '0;
            resume_q <= 1'b0;
            sdo_a    <= 1'b0;
            sdo_a_oe <= 1'b0;
            sdo_b    <= 1'b0;
            sdo_b_oe <= 1'b0;
        end else begin
            frame_q  <= frame_d;
            mode_q   <= mode_d;
            ptr_q    <= ptr_d;
            resume_q <= resume_d;
            sdo_a    <= a_d;
            sdo_a_oe <= oe_a_d;
            sdo_b    <= b_d;
            sdo_b_oe <= oe_b_d;
        end
    end

endmodule : adcemu_shift

// File: rtl/adcemu_top.sv
// adcemu_top: device-side serial source for two sample words. It ties the
// pin edge detector, the conversion timer and the frame serialiser together.
// Assumes conv_start, cs_n and sclk are synchronous to clk, and that each
// sclk phase lasts at least one clk period.
module adcemu_top
    import adcemu_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              one_wire,
    input  logic [WORD_W-1:0] smp_a,
    input  logic [WORD_W-1:0] smp_b,
    output logic              busy,
    output logic              sdo_a,
    output logic              sdo_a_oe,
    output logic              sdo_b,
    output logic              sdo_b_oe
);

    localparam int PIN_N   = 3;
    localparam int IX_SCLK = 0;
    localparam int IX_CS   = 1;
    localparam int IX_CONV = 2;

    logic [PIN_N-1:0]  pin_lvl, pin_rise, pin_fall;
    logic [WORD_W-1:0] res_a, res_b;
    lane_mode_e        mode_in;

    assign pin_lvl = {conv_start, cs_n, sclk};
    assign mode_in = one_wire ? LANE_SINGLE : LANE_DUAL;

    // Pin edges; chip select idles high, the others low.
    adcemu_edge #(
        .N      (PIN_N),
        .RST_LVL(PIN_N'(1) << IX_CS)
    ) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    // Conversion timing and word capture.
    adcemu_conv #(
        .WORD_W     (WORD_W),
        .CONV_CYCLES(CONV_CYCLES)
    ) conv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rise(pin_rise[IX_CONV]),
        .smp_a     (smp_a),
        .smp_b     (smp_b),
        .busy      (busy),
        .res_a     (res_a),
        .res_b     (res_b)
    );

    // Read frames on one or two lines.
    adcemu_shift #(
        .WORD_W(WORD_W)
    ) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_low   (~cs_n),
        .cs_fall  (pin_fall[IX_CS]),
        .cs_rise  (pin_rise[IX_CS]),
        .sclk_rise(pin_rise[IX_SCLK]),
        .mode_in  (mode_in),
        .res_a    (res_a),
        .res_b    (res_b),
        .sdo_a    (sdo_a),
        .sdo_a_oe (sdo_a_oe),
        .sdo_b    (sdo_b),
        .sdo_b_oe (sdo_b_oe)
    );

endmodule : adcemu_top

// File: rtl/adcemu_chk.sv
// adcemu_chk: timing properties of adcemu_top, seen from its pins only.
// It keeps its own copy of the start pin's previous level and a count of
// consecutive busy clocks, so the busy window is checked without deep $past.
module adcemu_chk #(
    parameter int CONV_CYCLES = 20
) (
    input logic clk,
    input logic rst_n,
    input logic conv_start,
    input logic cs_n,
    input logic busy,
    input logic sdo_a,
    input logic sdo_a_oe,
    input logic sdo_b,
    input logic sdo_b_oe
);

    logic        start_prev_q;
    int unsigned run_q;

    // Previous start level and the length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_prev_q <= 1'b0;
            run_q        <= 0;
        end else begin
            start_prev_q <= conv_start;
            run_q        <= busy ? run_q + 1 : 0;
        end
    end

    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !sdo_a_oe && !sdo_b_oe && !sdo_a && !sdo_b));

    p_start_raises_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !start_prev_q && !busy) |=> busy);

    p_busy_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == CONV_CYCLES));

    p_busy_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < CONV_CYCLES));

    p_float_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_a_oe && !sdo_b_oe && !sdo_a && !sdo_b));

    p_enable_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> sdo_a_oe);

    p_b_lane_needs_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_b_oe |-> sdo_a_oe);

endmodule : adcemu_chk

bind adcemu_top adcemu_chk #(
    .CONV_CYCLES(CONV_CYCLES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .cs_n      (cs_n),
    .busy      (busy),
    .sdo_a     (sdo_a),
    .sdo_a_oe  (sdo_a_oe),
    .sdo_b     (sdo_b),
    .sdo_b_oe  (sdo_b_oe)
);

// File: tb/adcemu_top_tb_top.sv
// Bench for adcemu_top: sweeps bit patterns through both lane modes, every
// pause count in one-lane mode, and the coincident-edge cases. Inputs are
// driven and outputs sampled on the falling clock edge.
module adcemu_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CONV_N     = 6;

    logic        clk = 1'b0;
    logic        rst_n, conv_start, cs_n, sclk, one_wire;
    logic [15:0] smp_a, smp_b;
    logic        busy, sdo_a, sdo_a_oe, sdo_b, sdo_b_oe;
    int          vec_n = 0;
    int          bad_n = 0;
    logic [15:0] cur_a, cur_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adcemu_top #(
        .WORD_W     (16),
        .CONV_CYCLES(CONV_N)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_start(conv_start),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .one_wire  (one_wire),
        .smp_a     (smp_a),
        .smp_b     (smp_b),
        .busy      (busy),
        .sdo_a     (sdo_a),
        .sdo_a_oe  (sdo_a_oe),
        .sdo_b     (sdo_b),
        .sdo_b_oe  (sdo_b_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_n++;
        if (act !== exp) begin
            bad_n++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse();
        sclk = 1'b1;
        tick();
        sclk = 1'b0;
        tick();
    endtask

    task automatic cs_down();
        cs_n = 1'b0;
        tick();
    endtask

    task automatic cs_up();
        cs_n = 1'b1;
        tick();
        chk("R5 lines off when deselected", {sdo_a_oe, sdo_b_oe, sdo_a, sdo_b}, 4'b0000);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 100 && busy; g++) tick();
    endtask

    // Start a conversion; optionally re-trigger while busy (R3).
    task automatic convert(input logic [15:0] a, input logic [15:0] b, input bit retrig);
        int n;
        smp_a = a;
        smp_b = b;
        conv_start = 1'b1;
        tick();
        chk("R2 busy after start", busy, 1);
        conv_start = 1'b0;
        smp_a = ~a;
        smp_b = ~b;
        n = 1;
        while (busy && n < 100) begin
            if (retrig && n == 2) conv_start = 1'b1;
            if (retrig && n == 3) conv_start = 1'b0;
            tick();
            if (busy) n++;
        end
        conv_start = 1'b0;
        chk(retrig ? "R3 busy length with retrigger" : "R2 busy length", n, CONV_N);
        cur_a = a;
        cur_b = b;
    endtask

    // Two-lane frame read; do_fall=0 when chip select is already low.
    task automatic read_dual(input logic [15:0] a, input logic [15:0] b, input bit do_fall,
                             input string tag);
        if (do_fall) cs_down();
        chk("R5 both enables on in two-lane mode", {sdo_a_oe, sdo_b_oe}, 2'b11);
        for (int i = 0; i < 16; i++) begin
            chk(i == 0 ? "R6 MSB at select" : tag, {sdo_a, sdo_b}, {a[15-i], b[15-i]});
            pulse();
        end
        chk("R8 zero after last bit", {sdo_a_oe, sdo_b_oe, sdo_a, sdo_b}, 4'b1100);
        pulse();
        chk("R8 zero after extra sclk", {sdo_a, sdo_b}, 2'b00);
        cs_up();
    endtask

    // One-lane read from bit position start (chip select already low).
    task automatic read_single(input logic [15:0] a, input logic [15:0] b, input int start,
                               input string tag);
        logic [31:0] stream;
        stream = {a, b};
        chk("R9 lane B off in one-lane mode", {sdo_a_oe, sdo_b_oe, sdo_b}, 3'b100);
        for (int p = start; p < 32; p++) begin
            chk(tag, sdo_a, stream[31-p]);
            pulse();
        end
        chk("R8 zero after 32 bits", {sdo_a_oe, sdo_a}, 2'b10);
    endtask

    initial begin
        rst_n = 1'b0;
        conv_start = 1'b0;
        cs_n = 1'b1;
        sclk = 1'b0;
        one_wire = 1'b0;
        smp_a = '0;
        smp_b = '0;
        cur_a = '0;
        cur_b = '0;
        repeat (3) tick();
        chk("R1 reset state", {busy, sdo_a_oe, sdo_b_oe, sdo_a, sdo_b}, 5'b00000);
        rst_n = 1'b1;
        tick();
        chk("R1 state after reset", {busy, sdo_a_oe, sdo_b_oe, sdo_a, sdo_b}, 5'b00000);

        // Pattern sweep, two-lane: walking one on A, inverse on B (R4, R7).
        for (int i = 0; i < 16; i++) begin
            convert(16'h1 << i, ~(16'h1 << i), 1'b0);
            read_dual(cur_a, cur_b, 1'b1, "R4/R7 two-lane bit");
        end
        convert(16'h0000, 16'hFFFF, 1'b0);
        read_dual(cur_a, cur_b, 1'b1, "R7 two-lane bit");
        convert(16'hA55A, 16'h3CC3, 1'b0);
        read_dual(cur_a, cur_b, 1'b1, "R7 two-lane bit");

        // Re-trigger while busy must not re-capture (R3).
        convert(16'h8421, 16'h1248, 1'b1);
        read_dual(16'h8421, 16'h1248, 1'b1, "R3 words kept after ignored start");

        // One-lane sweep over walking patterns (R9).
        one_wire = 1'b1;
        for (int i = 0; i < 16; i += 3) begin
            convert(16'h8000 >> i, 16'h0001 << i, 1'b0);
            cs_down();
            read_single(cur_a, cur_b, 0, "R9 one-lane bit");
            cs_up();
        end

        // Pause count sweep in one-lane mode (R10).
        convert(16'hC3A5, 16'h1E87, 1'b0);
        for (int k = 0; k <= 20; k++) begin
            cs_down();
            repeat (k) pulse();
            cs_up();
            cs_down();
            read_single(cur_a, cur_b, (k == 16) ? 16 : 0, "R10 restart or resume");
            cs_up();
        end

        // Two-lane never resumes (R10).
        one_wire = 1'b0;
        cs_down();
        repeat (16) pulse();
        cs_up();
        read_dual(cur_a, cur_b, 1'b1, "R10 two-lane restarts at A");

        // Conversion between the halves of a split one-lane frame (R11).
        one_wire = 1'b1;
        cs_down();
        repeat (16) pulse();
        cs_up();
        convert(16'h0F0F, 16'hF00F, 1'b0);
        cs_down();
        read_single(16'hC3A5, 16'h1E87, 16, "R11 resumed half keeps old copy");
        cs_up();
        cs_down();
        read_single(cur_a, cur_b, 0, "R11 next frame carries new words");
        cs_up();

        // Start edge in the same clock as chip-select fall (R11).
        one_wire = 1'b0;
        smp_a = 16'h5A5A;
        smp_b = 16'h6969;
        conv_start = 1'b1;
        cs_n = 1'b0;
        tick();
        conv_start = 1'b0;
        read_dual(cur_a, cur_b, 1'b0, "R11 frame unchanged by coincident start");
        wait_idle();
        cur_a = 16'h5A5A;
        cur_b = 16'h6969;
        read_dual(cur_a, cur_b, 1'b1, "R11 new words on following frame");

        // sclk rise in the same clock as chip-select fall (R11).
        sclk = 1'b1;
        cs_n = 1'b0;
        tick();
        chk("R11 MSB with coincident sclk", {sdo_a, sdo_b}, {cur_a[15], cur_b[15]});
        sclk = 1'b0;
        tick();
        read_dual(cur_a, cur_b, 1'b0, "R11 no advance on coincident sclk");

        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad_n++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

endmodule : adcemu_top_tb_top